// File: doc/BRIEF.md
# Command Ring Buffer Writer

This block streams 32-bit command words into a circular command buffer that lives in an attached controller's memory space. It keeps a local write offset into the ring and learns how far the controller has consumed by reading the controller's read-pointer register. Before each chunk it works out how much room is left. Four bytes of the ring are always held back, so a full ring can never look the same as an empty one. Words are then written one at a time at the ring base plus the running offset. When a chunk ends, the block publishes the new write offset to the controller's write-pointer register, wrapped to the ring size and rounded up to a 4-byte boundary.

Two synchronisation requests sit beside the command stream. An empty-wait polls both pointer registers until they match, then takes the controller's write pointer as the local offset. A start-up wait also requires the read pointer to reach zero and then clears the local offset. Every register and memory access goes through a single request/done transaction port. The command input uses a valid/ready handshake and stays not-ready while polling or publishing.

Top module: `cmdring_writer`

## Requirements
- R1: After rst_ni is released, bus_req_o is low, cmd_ready_o is low, flush_ready_o is high and the local offset is 0. With an empty controller, the first command word goes to RING_BASE and the offset published after it is 4.
- R2: Free space is (RING_BYTES - 4) minus ((offset - read pointer) mod RING_BYTES), using the low ring-width bits of the read pointer. A chunk carries at most floor(free/4) words. While free space is below 4 bytes, the block keeps re-reading RD_REG, cmd_ready_o stays low and no ring write is issued.
- R3: Word k (counting from 0) of a chunk is written with size code 2 (32-bit) to RING_BASE + ((offset + 4k) mod RING_BYTES), carrying the accepted word. Exactly one word is accepted per ring write.
- R4: A chunk ends after CHUNK_WORDS words, or as soon as cmd_valid_i is low while the block waits for the next word. The block then writes, with size code 1 (16-bit), the value ((offset + 4n) mod RING_BYTES + 3) with its two low bits cleared to WR_REG, where n is the chunk's word count. That value becomes the new offset.
- R5: An empty-wait (flush_logo_i low at acceptance) reads RD_REG and then WR_REG, and repeats both reads until the two values are equal. It then loads the low ring-width bits of the WR_REG value as the offset and pulses flush_done_o for one cycle.
- R6: A start-up wait (flush_logo_i high at acceptance) behaves like the empty-wait but also requires the read value to be 0. It then sets the offset to 0 and pulses flush_done_o.
- R7: A bus request keeps bus_we_o, bus_size_o, bus_addr_o and bus_wdata_o stable until the cycle in which bus_done_i is high. Read data is taken in that cycle. Pointer reads use size code 1.
- R8: cmd_ready_o is high only while the block waits for a word with no bus request pending. A wait request is accepted only while flush_ready_o is high, and it takes priority over a command word presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word offered |
| cmd_data_i | input | 32 | Command word |
| cmd_ready_o | output | 1 | Command word accepted this cycle when valid |
| flush_valid_i | input | 1 | Pointer-wait request |
| flush_logo_i | input | 1 | 1 selects the start-up wait, 0 the empty-wait |
| flush_ready_o | output | 1 | Block idle, wait request accepted |
| flush_done_o | output | 1 | One-cycle pulse when a wait completes |
| bus_req_o | output | 1 | Transaction request, held until done |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_size_o | output | 2 | 1 = 16-bit, 2 = 32-bit |
| bus_addr_o | output | ADDR_W | Byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_done_i | input | 1 | Transaction complete |
| bus_rdata_i | input | 32 | Read data, valid with bus_done_i |

## Verification
The checks assume that bus_done_i rises only while a request is pending and lasts a single cycle. They also assume that cmd_valid_i and flush_valid_i, once raised, stay high with stable data until accepted. The bench's transaction responder answers only pending requests, with a single-cycle done after a per-run latency of one to three cycles. Its stimulus tasks raise valid at a falling edge and hold it until ready is seen. Pointer values are moved only at falling edges, and only to states the block could legally observe.

// File: rtl/cmdring_pkg.sv
`timescale 1ns/1ps
package cmdring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_FEED, ST_WORD, ST_PUBL, ST_FRD, ST_FWR
  } ring_st_e;

  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/cmdring_space.sv
`timescale 1ns/1ps
module cmdring_space #(
  parameter int RING_W      = 12,
  parameter int CNT_W       = 4,
  parameter int CHUNK_WORDS = 8
) (
  input  logic [RING_W-1:0] off_i,
  input  logic [RING_W-1:0] rd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  limit_o,
  output logic [RING_W-1:0] addr_off_o,
  output logic [RING_W-1:0] pub_off_o
);
  localparam logic [RING_W-1:0] USABLE = RING_W'((1 << RING_W) - 4);
  localparam logic [RING_W-1:0] ALIGN  = RING_W'(3);

  logic [RING_W-1:0] fill, free, free_words, adv;

  always_comb begin
    fill = off_i - rd_i;
    // inconsistent pointers count as a full ring
    free = (fill > USABLE) ? '0 : USABLE - fill;
    free_words = free >> 2;
    if (free_words >= RING_W'(CHUNK_WORDS)) limit_o = CNT_W'(CHUNK_WORDS);
    else                                    limit_o = CNT_W'(free_words);
  end

  always_comb begin
    adv        = RING_W'({cnt_i, 2'b00});
    addr_off_o = off_i + adv;
    pub_off_o  = (addr_off_o + ALIGN) & ~ALIGN;
  end
endmodule

// File: rtl/cmdring_xfer.sv
`timescale 1ns/1ps
module cmdring_xfer #(
  parameter int ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              done_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [1:0]        bus_size_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_done_i
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_size_o  <= '0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
    end else if (start_i) begin
      // a new start may follow a done in the same cycle
      bus_req_o   <= 1'b1;
      bus_we_o    <= we_i;
      bus_size_o  <= size_i;
      bus_addr_o  <= addr_i;
      bus_wdata_o <= wdata_i;
    end else if (bus_done_i) begin
      bus_req_o <= 1'b0;
    end
  end

  assign done_o = bus_req_o & bus_done_i;
endmodule

// File: rtl/cmdring_writer.sv
`timescale 1ns/1ps
module cmdring_writer import cmdring_pkg::*; #(
  parameter int                ADDR_W      = 22,
  parameter int                RING_BYTES  = 4096,
  parameter int                CHUNK_WORDS = 8,
  parameter logic [ADDR_W-1:0] RING_BASE   = 22'h0A_0000,
  parameter logic [ADDR_W-1:0] RD_REG      = 22'h0F_0010,
  parameter logic [ADDR_W-1:0] WR_REG      = 22'h0F_0014
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cmd_data_i,
  output logic              cmd_ready_o,
  input  logic              flush_valid_i,
  input  logic              flush_logo_i,
  output logic              flush_ready_o,
  output logic              flush_done_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [1:0]        bus_size_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_done_i,
  input  logic [31:0]       bus_rdata_i
);
  localparam int RING_W = $clog2(RING_BYTES);
  localparam int CNT_W  = $clog2(CHUNK_WORDS + 1);

  ring_st_e          st_q, st_d;
  logic [RING_W-1:0] off_q, off_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, lim_q, lim_d;
  logic [31:0]       rd_q, rd_d;
  logic              logo_q, logo_d, fdone_q, fdone_d;

  logic              x_start, x_we, x_done;
  logic [1:0]        x_size;
  logic [ADDR_W-1:0] x_addr;
  logic [31:0]       x_wdata;

  logic [CNT_W-1:0]  lim_new;
  logic [RING_W-1:0] addr_off, pub_off;

  cmdring_space #(
    .RING_W(RING_W), .CNT_W(CNT_W), .CHUNK_WORDS(CHUNK_WORDS)
  ) u_space (
    .off_i      (off_q),
    .rd_i       (bus_rdata_i[RING_W-1:0]),
    .cnt_i      (cnt_q),
    .limit_o    (lim_new),
    .addr_off_o (addr_off),
    .pub_off_o  (pub_off)
  );

  cmdring_xfer #(.ADDR_W(ADDR_W)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (x_start),
    .we_i        (x_we),
    .size_i      (x_size),
    .addr_i      (x_addr),
    .wdata_i     (x_wdata),
    .done_o      (x_done),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_size_o  (bus_size_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_done_i  (bus_done_i)
  );

  always_comb begin
    st_d    = st_q;
    off_d   = off_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    rd_d    = rd_q;
    logo_d  = logo_q;
    fdone_d = 1'b0;
    x_start = 1'b0;
    x_we    = 1'b0;
    x_size  = SZ_HALF;
    x_addr  = RD_REG;
    x_wdata = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (flush_valid_i) begin
          x_start = 1'b1;
          logo_d  = flush_logo_i;
          st_d    = ST_FRD;
        end else if (cmd_valid_i) begin
          x_start = 1'b1;
          st_d    = ST_POLL;
        end
      end
      ST_POLL: begin
        if (x_done) begin
          if (lim_new != '0) begin
            cnt_d = '0;
            lim_d = lim_new;
            st_d  = ST_FEED;
          end else begin
            x_start = 1'b1; // no room: read the pointer again
          end
        end
      end
      ST_FEED: begin
        x_start = 1'b1;
        x_we    = 1'b1;
        if (cmd_valid_i) begin
          x_size  = SZ_WORD;
          x_addr  = RING_BASE + ADDR_W'(addr_off);
          x_wdata = cmd_data_i;
          cnt_d   = cnt_q + 1'b1;
          st_d    = ST_WORD;
        end else begin
          x_addr  = WR_REG;
          x_wdata = 32'(pub_off);
          st_d    = ST_PUBL;
        end
      end
      ST_WORD: begin
        if (x_done) begin
          if (cnt_q == lim_q) begin
            x_start = 1'b1;
            x_we    = 1'b1;
            x_addr  = WR_REG;
            x_wdata = 32'(pub_off);
            st_d    = ST_PUBL;
          end else begin
            st_d = ST_FEED;
          end
        end
      end
      ST_PUBL: begin
        if (x_done) begin
          off_d = pub_off;
          st_d  = ST_IDLE;
        end
      end
      ST_FRD: begin
        if (x_done) begin
          rd_d    = bus_rdata_i;
          x_start = 1'b1;
          x_addr  = WR_REG;
          st_d    = ST_FWR;
        end
      end
      ST_FWR: begin
        if (x_done) begin
          if (bus_rdata_i == rd_q && (!logo_q || rd_q == '0)) begin
            off_d   = logo_q ? '0 : bus_rdata_i[RING_W-1:0];
            fdone_d = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            x_start = 1'b1;
            st_d    = ST_FRD;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      off_q   <= '0;
      cnt_q   <= '0;
      lim_q   <= '0;
      rd_q    <= '0;
      logo_q  <= 1'b0;
      fdone_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      off_q   <= off_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      rd_q    <= rd_d;
      logo_q  <= logo_d;
      fdone_q <= fdone_d;
    end
  end

  assign cmd_ready_o   = (st_q == ST_FEED);
  assign flush_ready_o = (st_q == ST_IDLE);
  assign flush_done_o  = fdone_q;
endmodule

// File: rtl/cmdring_writer_chk.sv
`timescale 1ns/1ps
module cmdring_writer_chk #(
  parameter int                ADDR_W     = 22,
  parameter int                RING_BYTES = 4096,
  parameter logic [ADDR_W-1:0] RING_BASE  = 22'h0A_0000,
  parameter logic [ADDR_W-1:0] WR_REG     = 22'h0F_0014
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              flush_ready_o,
  input logic              flush_done_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [1:0]        bus_size_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [31:0]       bus_wdata_o,
  input logic              bus_done_i
);
  localparam logic [ADDR_W-1:0] RING_END = RING_BASE + ADDR_W'(RING_BYTES);

  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_done_i |=> bus_req_o && $stable(bus_we_o) && $stable(bus_size_o)
      && $stable(bus_addr_o) && $stable(bus_wdata_o)); // R7

  AST_READ_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o |-> bus_size_o == 2'd1); // R7

  AST_RING_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_size_o == 2'd2 |-> bus_addr_o >= RING_BASE && bus_addr_o < RING_END); // R3

  AST_ONE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o && cmd_valid_i |=> !cmd_ready_o && bus_req_o && bus_we_o); // R3

  AST_PUB_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == WR_REG |-> bus_size_o == 2'd1
      && bus_wdata_o[1:0] == 2'b00 && bus_wdata_o < 32'(RING_BYTES)); // R4

  AST_READY_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !bus_req_o && !flush_ready_o); // R8

  AST_FLUSH_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |-> flush_ready_o && !$past(flush_done_o)); // R5
endmodule

bind cmdring_writer cmdring_writer_chk #(
  .ADDR_W(ADDR_W), .RING_BYTES(RING_BYTES), .RING_BASE(RING_BASE), .WR_REG(WR_REG)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_ready_o   (cmd_ready_o),
  .flush_ready_o (flush_ready_o),
  .flush_done_o  (flush_done_o),
  .bus_req_o     (bus_req_o),
  .bus_we_o      (bus_we_o),
  .bus_size_o    (bus_size_o),
  .bus_addr_o    (bus_addr_o),
  .bus_wdata_o   (bus_wdata_o),
  .bus_done_i    (bus_done_i)
);

// File: tb/cmdring_writer_bench.sv
`timescale 1ns/1ps
module cmdring_writer_bench;
  localparam int          CHUNK = 4;
  localparam int          RING  = 4096;
  localparam logic [21:0] BASE  = 22'h0A_0000;
  localparam logic [21:0] RDR   = 22'h0F_0010;
  localparam logic [21:0] WRR   = 22'h0F_0014;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, flush_valid = 1'b0, flush_logo = 1'b0;
  logic [31:0] cmd_data = '0;
  logic cmd_ready, flush_ready, flush_done;
  logic bus_req, bus_we, bus_done;
  logic [1:0] bus_size;
  logic [21:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int n_chk = 0, n_fail = 0;
  int lat = 1, dev_rd = 0, dev_wr, wcnt;
  int preset_val = 0;
  bit preset_go = 1'b0, go_seen;
  int log_addr[512], log_data[512], log_size[512];
  int log_n, done_cnt;
  bit pdone;

  always #2.5 clk = ~clk;

  cmdring_writer #(.CHUNK_WORDS(CHUNK)) u_cmdring_writer (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data), .cmd_ready_o(cmd_ready),
    .flush_valid_i(flush_valid), .flush_logo_i(flush_logo),
    .flush_ready_o(flush_ready), .flush_done_o(flush_done),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_size_o(bus_size),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_done_i(bus_done), .bus_rdata_i(bus_rdata)
  );

  // controller model: pointer registers, write log
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_done <= 1'b0; bus_rdata <= '0; wcnt <= 0; dev_wr <= 0; go_seen <= 1'b0; log_n <= 0;
    end else begin
      if (preset_go != go_seen) begin go_seen <= preset_go; dev_wr <= preset_val; end
      if (bus_done) bus_done <= 1'b0;
      else if (bus_req) begin
        if (wcnt >= lat) begin
          wcnt <= 0;
          bus_done <= 1'b1;
          if (bus_we) begin
            if (bus_addr == WRR) dev_wr <= int'(bus_wdata[15:0]);
            if (log_n < 512) begin
              log_addr[log_n] <= int'(bus_addr);
              log_data[log_n] <= int'(bus_wdata);
              log_size[log_n] <= int'(bus_size);
            end
            log_n <= log_n + 1;
          end else begin
            bus_rdata <= (bus_addr == RDR) ? 32'(dev_rd) : (bus_addr == WRR) ? 32'(dev_wr) : 32'h0;
          end
        end else wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_cnt <= 0;
    else if (flush_done) done_cnt <= done_cnt + 1;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(int w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = 32'(w);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic drop();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 6) begin
      @(negedge clk);
      if (!bus_req && flush_ready && !cmd_valid) q++; else q = 0;
    end
  endtask

  task automatic set_wr(int v);
    @(negedge clk);
    preset_val = v;
    preset_go  = ~preset_go;
    @(negedge clk);
  endtask

  task automatic flush(bit logo);
    @(negedge clk);
    flush_valid = 1'b1;
    flush_logo  = logo;
    while (!flush_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    flush_valid = 1'b0;
  endtask

  task automatic wait_done(int d);
    int t = 0;
    while (done_cnt <= d && t < 400) begin @(negedge clk); t++; end
  endtask

  task automatic expect_write(string req, int k, int addr, int data, int size);
    check({req, " addr"}, log_addr[k], addr);
    check({req, " data"}, log_data[k], data);
    check({req, " size"}, log_size[k], size);
  endtask

  // sweep run: offset reloaded by empty-wait, then n words streamed
  task automatic run(int off0, int n);
    int d, s, o, k, i, c;
    set_wr(off0);
    dev_rd = off0;
    d = done_cnt;
    flush(1'b0);
    wait_done(d);
    check("R5 reload done", done_cnt, d + 1);
    s = log_n;
    for (int j = 0; j < n; j++) push(32'h5000_0000 ^ (off0 << 8) ^ (n << 4) ^ j);
    drop();
    wait_idle();
    o = off0; k = s; i = 0;
    while (i < n) begin
      c = (n - i < CHUNK) ? n - i : CHUNK;
      for (int j = 0; j < c; j++) begin
        expect_write("R3 ring word", k, int'(BASE) + ((o + 4 * j) % RING),
                     32'h5000_0000 ^ (off0 << 8) ^ (n << 4) ^ (i + j), 2);
        k++;
      end
      o = (((o + 4 * c) % RING) + 3) & 32'hFFC;
      expect_write("R4 publish", k, int'(WRR), o, 1);
      k++;
      i += c;
    end
    check("R4 write count", log_n, k);
  endtask

  initial begin
    int s, d, x;
    int offs[5] = '{0, 6, 4080, 4086, 4092};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bus_req", int'(bus_req), 0);
    check("R1 cmd_ready", int'(cmd_ready), 0);
    check("R1 flush_ready", int'(flush_ready), 1);

    // R1: offset 0 after reset
    dev_rd = 0;
    push(32'hA5A5_0001);
    drop();
    wait_idle();
    expect_write("R1 first word", 0, int'(BASE), 32'hA5A5_0001, 2);
    expect_write("R1 first publish", 1, int'(WRR), 4, 1);
    check("R1 count", log_n, 2);

    // R3 R4 sweep over start offsets, lengths and bus latencies
    for (int a = 0; a < 5; a++)
      for (int n = 1; n <= 6; n++) begin
        lat = (n + a) % 3 + 1;
        run(offs[a], n);
      end
    lat = 1;

    // R8: wait request and command together, wait wins
    wait_idle();
    dev_rd = dev_wr;
    x = dev_wr;
    s = log_n;
    d = done_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = 32'hC0DE_0008;
    flush_valid = 1'b1; flush_logo = 1'b0;
    @(posedge clk);
    @(negedge clk);
    flush_valid = 1'b0;
    wait_done(d);
    check("R8 wait first, done", done_cnt, d + 1);
    check("R8 no ring write before done", log_n, s);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    drop();
    wait_idle();
    expect_write("R8 word after wait", s, int'(BASE) + x, 32'hC0DE_0008, 2);

    // R2: room for two words only, then none
    x = dev_wr;
    dev_rd = (x + 12) % RING;
    s = log_n;
    pdone = 1'b0;
    fork
      begin
        push(32'h0000_A001); push(32'h0000_A002); push(32'h0000_A003); drop(); pdone = 1'b1;
      end
    join_none
    repeat (120) @(negedge clk);
    check("R2 chunk limited by space", log_n - s, 3);
    expect_write("R2 word0", s, int'(BASE) + x, 32'h0000_A001, 2);
    expect_write("R2 word1", s + 1, int'(BASE) + ((x + 4) % RING), 32'h0000_A002, 2);
    expect_write("R2 publish", s + 2, int'(WRR), (x + 8) % RING, 1);
    check("R2 stalled not ready", int'(cmd_ready), 0);
    check("R2 stalled word pending", int'(pdone), 0);
    dev_rd = (x + 8) % RING;
    while (!pdone) @(negedge clk);
    wait_idle();
    expect_write("R2 resumed word", s + 3, int'(BASE) + ((x + 8) % RING), 32'h0000_A003, 2);
    expect_write("R2 resumed publish", s + 4, int'(WRR), (x + 12) % RING, 1);
    check("R2 count", log_n, s + 5);

    // R5: mismatched pointers hold the empty-wait
    set_wr(40);
    dev_rd = 36;
    d = done_cnt;
    flush(1'b0);
    repeat (80) @(negedge clk);
    check("R5 held on mismatch", done_cnt, d);
    dev_rd = 40;
    wait_done(d);
    check("R5 done on match", done_cnt, d + 1);
    s = log_n;
    push(32'h0000_B040);
    drop();
    wait_idle();
    expect_write("R5 reloaded offset", s, int'(BASE) + 40, 32'h0000_B040, 2);
    expect_write("R5 publish", s + 1, int'(WRR), 44, 1);

    // R6: start-up wait needs read pointer 0
    set_wr(16);
    dev_rd = 16;
    d = done_cnt;
    flush(1'b1);
    repeat (80) @(negedge clk);
    check("R6 held on nonzero match", done_cnt, d);
    set_wr(0);
    dev_rd = 0;
    wait_done(d);
    check("R6 done at zero", done_cnt, d + 1);
    s = log_n;
    push(32'h0000_C000);
    drop();
    wait_idle();
    expect_write("R6 offset cleared", s, int'(BASE), 32'h0000_C000, 2);
    expect_write("R6 publish", s + 1, int'(WRR), 4, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule